// File: doc/BRIEF.md
# Glitch-free clock-stop controller

The controller derives six groups of clock outputs from one master clock: a processor clock and its free-running twin, a memory clock, a graphics-port clock, a bank of peripheral-bus clocks and a free-running peripheral clock. Each group's waveform comes from a divider that counts master cycles. Each group has a gate that can hold its output low.

Three active-low asynchronous inputs drive the gates. The processor stop input always stops the processor clock. A 2-bit select decides whether it also stops the memory group, the graphics group, or both. The peripheral stop input halts the gated peripheral bank. The power-down input pulls every output low, including the free-running ones. A gate decides only on the master edge where its source clock falls. A clock therefore never stops in a high phase and never restarts with a short high pulse. After each restart the processor gate and the peripheral gate enforce a minimum run time. A stop that arrives inside that window waits until the window ends.

Top module: `clk_stop_ctrl`

## Requirements
- R1: Once reset is released, the free-running processor and peripheral outputs toggle with periods of 2*CPU_HALF and 2*PCI_HALF master cycles. Neither stop input changes them.
- R2: Every high phase of every output lasts exactly its group's half period in master cycles. A gated output stops only in the low state.
- R3: If the minimum-run window is closed, a falling `cpu_stop_ni` holds `cpu_clk_o` low no later than SYNC_STAGES+2*CPU_HALF master cycles after the fall. Its release brings the first rising edge within SYNC_STAGES+3*CPU_HALF master cycles. With the defaults both bounds are under 4 processor periods.
- R4: A restarted processor clock gives exactly CPU_MIN_RUN high pulses before a stop request can halt it. This holds when the request was already pending during that window. The deferred request then takes effect without being repeated.
- R5: A low `pci_stop_ni` holds every bit of `pci_clk_o` low within SYNC_STAGES+2*PCI_HALF master cycles, and its release restarts them within SYNC_STAGES+3*PCI_HALF. After a restart they give exactly PCI_MIN_RUN pulses before a pending stop applies. The processor, memory and graphics clocks keep running.
- R6: The select `cpu_grp_sel_i` sets which groups follow the processor stop. 2'b00 stops the processor clock only. 2'b01 also stops memory and graphics. 2'b10 also stops memory. 2'b11 also stops graphics.
- R7: When `pd_ni` is low, each output goes low at its next falling boundary and produces no further rising edge. Both stop inputs are ignored while this lasts.
- R8: When `pd_ni` is released, the outputs resume, and each gated group obeys the stop inputs as they then stand.
- R9: During reset all outputs are low. Every gate comes out of reset enabled with its minimum-run window closed, so a first stop request acts at once.
- R10: The gated processor and peripheral outputs are never high while their free-running counterparts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock from which all group clocks are divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_stop_ni | input | 1 | Asynchronous active-low processor-group stop request |
| pci_stop_ni | input | 1 | Asynchronous active-low peripheral-bank stop request |
| pd_ni | input | 1 | Asynchronous active-low power-down request |
| cpu_grp_sel_i | input | 2 | Selects which groups follow the processor stop (see R6) |
| cpu_clk_o | output | 1 | Gated processor clock |
| cpu_free_o | output | 1 | Free-running processor clock |
| mem_clk_o | output | 1 | Gated memory clock |
| agp_clk_o | output | 1 | Gated graphics-port clock |
| pci_clk_o | output | PCI_N | Gated peripheral-bus clocks |
| pci_free_o | output | 1 | Free-running peripheral clock |

## Verification
On every cycle the assertions check three things. A gated clock never rises apart from its free-running twin. A gated clock is never high while the twin is low. No output rises once the synchronised power-down is present. Latency bounds, the exact minimum-run pulse counts, the group-select decoding and resumption after power-down all need a stimulus history to test. The bench's directed scenarios show those. Its randomised stop and power-down traffic is checked for full-width high phases on every output.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;

   typedef enum logic [1:0] {
      GSEL_CPU_ONLY = 2'b00,
      GSEL_ALL      = 2'b01,
      GSEL_MEM      = 2'b10,
      GSEL_AGP      = 2'b11
   } grp_sel_e;

   function automatic logic mem_follows(input logic [1:0] sel);
      return (sel == GSEL_ALL) || (sel == GSEL_MEM);
   endfunction

   function automatic logic agp_follows(input logic [1:0] sel);
      return (sel == GSEL_ALL) || (sel == GSEL_AGP);
   endfunction

endpackage

// File: rtl/clk_stop_sync.sv
`timescale 1ns/1ps
module clk_stop_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("clk_stop_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
      else         ff_q <= {ff_q[STAGES-2:0], async_i};
   end

   assign sync_o = ff_q[STAGES-1];
endmodule

// File: rtl/clk_stop_div.sv
`timescale 1ns/1ps
module clk_stop_div #(
   parameter int HALF = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic rise_o,
   output logic fall_o
);
   if (HALF < 1) begin : g_bad_half
      $error("clk_stop_div: HALF must be at least 1");
   end

   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   logic [CW-1:0] cnt_q;
   logic          src_q;
   logic          last;

   assign last = (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         src_q <= 1'b0;
      end else if (last) begin
         cnt_q <= '0;
         src_q <= ~src_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // Flags name the edge at which the source toggles.
   assign rise_o = last & ~src_q;
   assign fall_o = last &  src_q;
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
   parameter int MIN_RUN = 0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rise_i,
   input  logic fall_i,
   input  logic stop_i,
   input  logic pd_i,
   output logic clk_o
);
   if (MIN_RUN < 0) begin : g_bad_min
      $error("clk_stop_gate: MIN_RUN must not be negative");
   end

   logic en_q, out_q, next_en, win_open;

   // Power-down wins; a stop inside the run window is held off.
   assign next_en = pd_i    ? 1'b0 :
                    !stop_i ? 1'b1 : (en_q & win_open);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q  <= 1'b1;
         out_q <= 1'b0;
      end else if (fall_i) begin
         out_q <= 1'b0;
         en_q  <= next_en;
      end else if (rise_i) begin
         out_q <= en_q & ~pd_i;
      end
   end

   if (MIN_RUN == 0) begin : g_no_window
      assign win_open = 1'b0;
   end else begin : g_window
      localparam int RW = $clog2(MIN_RUN + 1);
      logic [RW-1:0] run_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            run_q <= RW'(MIN_RUN);
         else if (fall_i && !en_q && next_en)
            run_q <= '0;
         else if (rise_i && en_q && !pd_i && win_open)
            run_q <= run_q + 1'b1;
      end

      assign win_open = (run_q < RW'(MIN_RUN));
   end

   assign clk_o = out_q;
endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl
   import clk_stop_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CPU_HALF    = 2,
   parameter int MEM_HALF    = 2,
   parameter int AGP_HALF    = 3,
   parameter int PCI_HALF    = 4,
   parameter int CPU_MIN_RUN = 100,
   parameter int PCI_MIN_RUN = 10,
   parameter int PCI_N       = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cpu_stop_ni,
   input  logic             pci_stop_ni,
   input  logic             pd_ni,
   input  logic [1:0]       cpu_grp_sel_i,
   output logic             cpu_clk_o,
   output logic             cpu_free_o,
   output logic             mem_clk_o,
   output logic             agp_clk_o,
   output logic [PCI_N-1:0] pci_clk_o,
   output logic             pci_free_o
);
   if (PCI_N < 1) begin : g_bad_pci_n
      $error("clk_stop_ctrl: PCI_N must be at least 1");
   end

   logic cpu_sync_n, pci_sync_n, pd_sync_n;
   logic cpu_req, pci_req, pd_req;
   logic cpu_rise, cpu_fall, mem_rise, mem_fall;
   logic agp_rise, agp_fall, pci_rise, pci_fall;
   logic pci_gated;

   clk_stop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cpu (
      .clk_i(clk_i), .rst_ni(rst_ni), .async_i(cpu_stop_ni), .sync_o(cpu_sync_n));
   clk_stop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pci (
      .clk_i(clk_i), .rst_ni(rst_ni), .async_i(pci_stop_ni), .sync_o(pci_sync_n));
   clk_stop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pd (
      .clk_i(clk_i), .rst_ni(rst_ni), .async_i(pd_ni), .sync_o(pd_sync_n));

   assign cpu_req = ~cpu_sync_n;
   assign pci_req = ~pci_sync_n;
   assign pd_req  = ~pd_sync_n;

   clk_stop_div #(.HALF(CPU_HALF)) u_div_cpu (
      .clk_i(clk_i), .rst_ni(rst_ni), .rise_o(cpu_rise), .fall_o(cpu_fall));
   clk_stop_div #(.HALF(MEM_HALF)) u_div_mem (
      .clk_i(clk_i), .rst_ni(rst_ni), .rise_o(mem_rise), .fall_o(mem_fall));
   clk_stop_div #(.HALF(AGP_HALF)) u_div_agp (
      .clk_i(clk_i), .rst_ni(rst_ni), .rise_o(agp_rise), .fall_o(agp_fall));
   clk_stop_div #(.HALF(PCI_HALF)) u_div_pci (
      .clk_i(clk_i), .rst_ni(rst_ni), .rise_o(pci_rise), .fall_o(pci_fall));

   clk_stop_gate #(.MIN_RUN(CPU_MIN_RUN)) u_gate_cpu (
      .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(cpu_rise), .fall_i(cpu_fall),
      .stop_i(cpu_req), .pd_i(pd_req), .clk_o(cpu_clk_o));
   clk_stop_gate #(.MIN_RUN(0)) u_gate_cpu_free (
      .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(cpu_rise), .fall_i(cpu_fall),
      .stop_i(1'b0), .pd_i(pd_req), .clk_o(cpu_free_o));
   clk_stop_gate #(.MIN_RUN(0)) u_gate_mem (
      .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(mem_rise), .fall_i(mem_fall),
      .stop_i(cpu_req & mem_follows(cpu_grp_sel_i)), .pd_i(pd_req), .clk_o(mem_clk_o));
   clk_stop_gate #(.MIN_RUN(0)) u_gate_agp (
      .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(agp_rise), .fall_i(agp_fall),
      .stop_i(cpu_req & agp_follows(cpu_grp_sel_i)), .pd_i(pd_req), .clk_o(agp_clk_o));
   clk_stop_gate #(.MIN_RUN(PCI_MIN_RUN)) u_gate_pci (
      .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(pci_rise), .fall_i(pci_fall),
      .stop_i(pci_req), .pd_i(pd_req), .clk_o(pci_gated));
   clk_stop_gate #(.MIN_RUN(0)) u_gate_pci_free (
      .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(pci_rise), .fall_i(pci_fall),
      .stop_i(1'b0), .pd_i(pd_req), .clk_o(pci_free_o));

   assign pci_clk_o = {PCI_N{pci_gated}};
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
`timescale 1ns/1ps
module clk_stop_ctrl_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic pd_req,
   input logic cpu_clk,
   input logic cpu_free,
   input logic mem_clk,
   input logic pci_clk,
   input logic pci_free
);
   AST_CPU_INSIDE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_clk |-> cpu_free); // R10
   AST_PCI_INSIDE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pci_clk |-> pci_free); // R10
   AST_CPU_RISE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cpu_clk) |-> $rose(cpu_free)); // R2
   AST_PCI_RISE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pci_clk) |-> $rose(pci_free)); // R2
   AST_PD_HOLD_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pd_req && !cpu_free) |=> !cpu_free); // R7
   AST_PD_HOLD_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pd_req && !mem_clk) |=> !mem_clk); // R7
   AST_PD_HOLD_PCI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pd_req && !pci_free) |=> !pci_free); // R7
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .pd_req  (pd_req),
   .cpu_clk (cpu_clk_o),
   .cpu_free(cpu_free_o),
   .mem_clk (mem_clk_o),
   .pci_clk (pci_clk_o[0]),
   .pci_free(pci_free_o)
);

// File: tb/clk_stop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_stop_ctrl_tb_top;
   localparam int SYNC = 2, CH = 2, MH = 2, AH = 3, PH = 4;
   localparam int CMIN = 100, PMIN = 10, PN = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pd_n = 1'b1;
   logic [1:0] sel = 2'b00;
   logic cpu_clk, cpu_free, mem_clk, agp_clk, pci_free;
   logic [PN-1:0] pci_clk;

   clk_stop_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cpu_stop_ni(cpu_stop_n), .pci_stop_ni(pci_stop_n),
      .pd_ni(pd_n), .cpu_grp_sel_i(sel), .cpu_clk_o(cpu_clk), .cpu_free_o(cpu_free),
      .mem_clk_o(mem_clk), .agp_clk_o(agp_clk), .pci_clk_o(pci_clk), .pci_free_o(pci_free));

   always #4 clk = ~clk;

   // bit order: 0 cpu, 1 cpu_free, 2 mem, 3 agp, 4 pci, 5 pci_free
   wire [5:0] obs = {pci_free, pci_clk[0], agp_clk, mem_clk, cpu_free, cpu_clk};
   int half_of [6] = '{CH, CH, MH, AH, PH, PH};
   int errors = 0, checks = 0;
   int rises [6];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic near(input int act, input int exp, input string req, input string what);
      chk(act >= exp - 1 && act <= exp + 1, req, what, act, exp);
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic watch(input int n);
      logic [5:0] prev;
      prev = obs;
      for (int i = 0; i < 6; i++) rises[i] = 0;
      repeat (n) begin
         @(negedge clk);
         for (int i = 0; i < 6; i++) if (obs[i] && !prev[i]) rises[i]++;
         prev = obs;
      end
   endtask

   task automatic wait_rise(input int b, input int limit, output int k);
      k = 0;
      for (int j = 1; j <= limit; j++) begin
         @(negedge clk);
         if (obs[b]) begin k = j; break; end
      end
   endtask

   function automatic bit exp_mem_stop(input logic [1:0] s);
      return (s == 2'b01) || (s == 2'b10);
   endfunction
   function automatic bit exp_agp_stop(input logic [1:0] s);
      return (s == 2'b01) || (s == 2'b11);
   endfunction

   // Continuous monitor: full-width high phases (R2), gated inside free (R10).
   int hrun [6];
   logic [5:0] pv;
   always @(negedge clk) begin
      if (!rst_n) begin
         pv = '0;
         for (int i = 0; i < 6; i++) hrun[i] = 0;
      end else begin
         for (int i = 0; i < 6; i++) begin
            if (obs[i]) hrun[i]++;
            else if (pv[i]) begin
               chk(hrun[i] == half_of[i], "R2", $sformatf("high width bit%0d", i),
                   hrun[i], half_of[i]);
               hrun[i] = 0;
            end
         end
         if (obs[0] && !obs[1]) chk(1'b0, "R10", "cpu high, free low", 1, 0);
         if (obs[4] && !obs[5]) chk(1'b0, "R10", "pci high, free low", 1, 0);
         if (pci_clk != '0 && pci_clk != '1) chk(1'b0, "R5", "pci bits differ", pci_clk, 0);
         pv = obs;
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int k, total;
      void'($urandom(32'd1234));
      // R9 reset state
      repeat (3) begin
         @(negedge clk);
         chk(obs == 6'b0 && pci_clk == '0, "R9", "outputs low in reset", obs, 0);
      end
      rst_n = 1'b1;

      // R1 free running, everything enabled
      watch(64);
      near(rises[1], 64 / (2 * CH), "R1", "cpu free rises");
      near(rises[5], 64 / (2 * PH), "R1", "pci free rises");
      near(rises[0], 64 / (2 * CH), "R9", "cpu gated runs after reset");

      // R3 off latency, first stop acts at once (R9), sel 00 (R6)
      cpu_stop_n = 1'b0;
      cyc(SYNC + 2 * CH);
      watch(40);
      chk(rises[0] == 0, "R3", "cpu stopped", rises[0], 0);
      chk(obs[0] == 1'b0, "R3", "cpu stopped low", obs[0], 0);
      near(rises[1], 40 / (2 * CH), "R1", "cpu free during stop");
      chk(rises[2] > 0 && rises[3] > 0 && rises[4] > 0, "R6", "sel00 others run",
          rises[2] + rises[3], 1);

      // R3 on latency then R4 minimum run with deferred stop
      cpu_stop_n = 1'b1;
      wait_rise(0, 30, k);
      chk(k > 0 && k <= SYNC + 3 * CH, "R3", "restart latency", k, SYNC + 3 * CH);
      cpu_stop_n = 1'b0;
      total = 1;
      watch(CMIN * 2 * CH + 80);
      total += rises[0];
      chk(total == CMIN, "R4", "pulses in run window", total, CMIN);
      watch(40);
      chk(rises[0] == 0, "R4", "deferred stop applied", rises[0], 0);

      // R6 group select
      for (int s = 0; s < 4; s++) begin
         cpu_stop_n = 1'b1;
         sel = 2'(s);
         cyc(40);
         cpu_stop_n = 1'b0;
         cyc(SYNC + 2 * AH + 2);
         watch(48);
         chk((rises[2] == 0) == exp_mem_stop(2'(s)), "R6", $sformatf("mem sel=%0d", s),
             rises[2], exp_mem_stop(2'(s)) ? 0 : 12);
         chk((rises[3] == 0) == exp_agp_stop(2'(s)), "R6", $sformatf("agp sel=%0d", s),
             rises[3], exp_agp_stop(2'(s)) ? 0 : 8);
      end
      cpu_stop_n = 1'b1;
      sel = 2'b00;
      cyc(20);

      // R5 peripheral stop, latency, minimum run
      pci_stop_n = 1'b0;
      cyc(SYNC + 2 * PH);
      watch(64);
      chk(rises[4] == 0, "R5", "pci stopped", rises[4], 0);
      near(rises[5], 64 / (2 * PH), "R1", "pci free during stop");
      chk(rises[0] > 0 && rises[2] > 0 && rises[3] > 0, "R5", "other groups run",
          rises[0], 16);
      pci_stop_n = 1'b1;
      wait_rise(4, 40, k);
      chk(k > 0 && k <= SYNC + 3 * PH, "R5", "pci restart latency", k, SYNC + 3 * PH);
      pci_stop_n = 1'b0;
      total = 1;
      watch(PMIN * 2 * PH + 40);
      total += rises[4];
      chk(total == PMIN, "R5", "pci pulses in run window", total, PMIN);

      // R7 power-down, stops ignored
      pd_n = 1'b0;
      cyc(SYNC + 2 * PH + 2);
      chk(obs == 6'b0, "R7", "all low in power-down", obs, 0);
      cpu_stop_n = 1'b0;
      watch(32);
      total = rises[0] + rises[1] + rises[2] + rises[3] + rises[4] + rises[5];
      cpu_stop_n = 1'b1;
      pci_stop_n = 1'b1;
      watch(32);
      total += rises[0] + rises[1] + rises[2] + rises[3] + rises[4] + rises[5];
      chk(total == 0, "R7", "no edges while down", total, 0);
      chk(obs == 6'b0, "R7", "still low", obs, 0);

      // R8 resume with current stops
      pci_stop_n = 1'b0;
      pd_n = 1'b1;
      cyc(SYNC + 3 * PH + 2);
      watch(64);
      chk(rises[0] > 0 && rises[2] > 0, "R8", "cpu and mem resume", rises[0], 16);
      chk(rises[4] == 0, "R8", "pci stays stopped", rises[4], 0);
      near(rises[5], 64 / (2 * PH), "R8", "pci free resumes");
      pci_stop_n = 1'b1;

      // random traffic, monitored for R2 and R10
      for (int n = 0; n < 60; n++) begin
         cpu_stop_n = 1'($urandom_range(0, 1));
         pci_stop_n = 1'($urandom_range(0, 1));
         sel        = 2'($urandom_range(0, 3));
         pd_n       = ($urandom_range(0, 7) != 0);
         cyc($urandom_range(1, 60));
      end
      cpu_stop_n = 1'b1;
      pci_stop_n = 1'b1;
      pd_n = 1'b1;
      cyc(SYNC + 3 * PH + 2);
      watch(64);
      near(rises[1], 64 / (2 * CH), "R1", "cpu free after random");
      near(rises[0], 64 / (2 * CH), "R3", "cpu running after random");
      near(rises[4], 64 / (2 * PH), "R5", "pci running after random");
      finish_run();
   end
endmodule